// File: doc/BRIEF.md
# BCH Error-Position Bit Flipper

This block takes the result of an external BCH decoder and applies it to a 512-byte sector held in a byte-wide buffer. The decoder presents a status byte and four 32-bit words of packed error positions. A one-cycle ready flag qualifies them. When the block is idle and sees the ready flag, it captures all of them. It then walks through the reported positions in order. For each position that falls inside the data area, it reads the addressed byte, flips the single faulty bit and writes the byte back.

Positions that point past the data area belong to the parity bytes. They are skipped and not counted. When the walk ends, the block raises a one-cycle done pulse. With the pulse it presents either the number of bits it flipped or a flag saying the sector cannot be corrected. Syndrome computation and error location are done upstream and are not part of this block.

Top module: `bchfix_apply`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `busy`, `memRe` and `memWe` are all low.
- R2: A job starts only on a clock edge where `decReady` is high and the block is idle; `busy` is high from the next cycle. A `decReady` seen while busy is ignored, together with any change of `statWord` or `posWords` during the job.
- R3: `statWord` is decoded as follows: bit 1 is errors-found, bit 0 is uncorrectable, and bits [7:4] are the error count. When errors-found is 0, the job ends with `fixCount` 0 and `failed` 0, and the buffer is not accessed, whatever the other bits hold.
- R4: When errors-found is 1 and uncorrectable is 1, the job ends with `failed` 1 and `fixCount` 0, and the buffer is not accessed.
- R5: Position k (k = 0..7) sits in 32-bit word k/2 of `posWords` (word 0 in bits [31:0]). Even k uses bits [12:0] and odd k uses bits [28:16]; all other bits are ignored. Positions are processed in increasing k. Only the first N are processed, where N is the error count, and a count above 8 is treated as 8.
- R6: A position p below 4096 is applied as a read of byte p>>3 with `memRe`. In the following cycle comes a write of the same address with `memWe`, whose data is the read byte with bit p&7 inverted. The buffer returns read data one cycle after `memRe`.
- R7: A position of 4096 or more is neither written nor counted.
- R8: `done` is a single-cycle pulse, and `fixCount` with it equals the number of positions applied. After the accepting edge, `done` is high in the cycle after 1 + 3a + s further edges. Here a is the number of positions applied and s the number skipped; a job that applies nothing has a = s = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decReady | input | 1 | Decoder result valid |
| statWord | input | 8 | Decoder status: flags and error count |
| posWords | input | 128 | Four words of packed error positions |
| memAddr | output | 9 | Buffer byte address |
| memRe | output | 1 | Buffer read strobe |
| memWe | output | 1 | Buffer write strobe |
| memWdata | output | 8 | Buffer write data |
| memRdata | input | 8 | Buffer read data, one cycle after `memRe` |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| fixCount | output | 4 | Number of bits flipped |
| failed | output | 1 | Sector reported uncorrectable |

## Verification
The hardest situation to reach from the ports is a job where two positions land in the same byte. There the second read must return the byte already changed by the first write. The stimulus reaches it by injecting bit 0 and bit 7 of byte 0 into a golden buffer and reporting both positions. A restore check over the whole sector then shows whether the read-modify-write order is kept. Other cases reach harder corners:
- Positions that lie past the data area mixed with in-range ones, including 4095 and 4096.
- An error count larger than eight.
- Valid-looking positions beyond the count, which must stay untouched.
- A ready flag held high with different data for the whole job, which must not change the result.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;

  localparam int STAT_W        = 8;
  localparam int STAT_UNC_BIT  = 0;
  localparam int STAT_FND_BIT  = 1;
  localparam int STAT_CNT_LSB  = 4;
  localparam int STAT_CNT_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_MODIFY,
    ST_DONE
  } fixState_t;

  typedef struct packed {
    logic load;
    logic step;
    logic rd;
    logic wr;
    logic finish;
  } fixStrobe_t;

endpackage

// File: rtl/bchfix_ctrl.sv
module bchfix_ctrl
  import bchfix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       decReady,
  input  logic       found,
  input  logic       uncorr,
  input  logic       atLimit,
  input  logic       inRange,
  output fixStrobe_t strobe,
  output logic       busy
);

  fixState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (decReady) begin
          strobe.load = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        // stop early on a clean or hopeless sector, or when the count is used up
        if (!found || uncorr || atLimit) nextState = ST_DONE;
        else if (inRange)                nextState = ST_READ;
        else                             strobe.step = 1'b1;
      end
      ST_READ: begin
        strobe.rd = 1'b1;
        nextState = ST_MODIFY;
      end
      ST_MODIFY: begin
        strobe.wr   = 1'b1;
        strobe.step = 1'b1;
        nextState   = ST_CHECK;
      end
      ST_DONE: begin
        strobe.finish = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/bchfix_dpath.sv
module bchfix_dpath
  import bchfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int POS_W        = 13,
  parameter int MAX_ERR      = 8,
  localparam int WORDS       = MAX_ERR / 2,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int IDX_W       = $clog2(MAX_ERR + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  fixStrobe_t          strobe,
  input  logic [STAT_W-1:0]   statWord,
  input  logic [WORDS*32-1:0] posWords,
  input  logic [7:0]          memRdata,
  output logic                found,
  output logic                uncorr,
  output logic                atLimit,
  output logic                inRange,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [7:0]          memWdata,
  output logic [IDX_W-1:0]    fixCount,
  output logic                failed
);

  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int SEL_W     = $clog2(MAX_ERR);

  logic [POS_W-1:0]      posIn  [MAX_ERR];
  logic [POS_W-1:0]      posReg [MAX_ERR];
  logic [STAT_CNT_W-1:0] regCount;
  logic [IDX_W-1:0]      idx, errLimit, applied;
  logic [POS_W-1:0]      curPos;

  // two positions per 32-bit word: low half first, then high half
  for (genvar g = 0; g < MAX_ERR; g++) begin : g_unpack
    assign posIn[g] = posWords[(g / 2) * 32 + (g % 2) * 16 +: POS_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_ERR; i++) posReg[i] <= '0;
      regCount <= '0;
      found    <= 1'b0;
      uncorr   <= 1'b0;
    end else if (strobe.load) begin
      for (int i = 0; i < MAX_ERR; i++) posReg[i] <= posIn[i];
      regCount <= statWord[STAT_CNT_LSB +: STAT_CNT_W];
      found    <= statWord[STAT_FND_BIT];
      uncorr   <= statWord[STAT_UNC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      applied <= '0;
    end else if (strobe.load) begin
      idx     <= '0;
      applied <= '0;
    end else begin
      if (strobe.step) idx     <= idx + 1'b1;
      if (strobe.wr)   applied <= applied + 1'b1;
    end
  end

  // a reported count beyond the position slots is clamped
  always_comb begin
    if (int'(regCount) > MAX_ERR) errLimit = IDX_W'(MAX_ERR);
    else                          errLimit = IDX_W'(regCount);
  end

  assign atLimit  = (idx >= errLimit);
  assign curPos   = posReg[idx[SEL_W-1:0]];
  assign inRange  = (32'(curPos) < DATA_BITS);
  assign memAddr  = curPos[ADDR_W+2:3];
  assign memWdata = memRdata ^ (8'd1 << curPos[2:0]);
  assign fixCount = applied;
  assign failed   = found & uncorr;

  logic unusedInputs;
  assign unusedInputs = ^{posWords, statWord, strobe.rd, strobe.finish};

endmodule

// File: rtl/bchfix_apply.sv
module bchfix_apply
  import bchfix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int POS_W        = 13,
  parameter int MAX_ERR      = 8,
  localparam int WORDS       = MAX_ERR / 2,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int IDX_W       = $clog2(MAX_ERR + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                decReady,
  input  logic [STAT_W-1:0]   statWord,
  input  logic [WORDS*32-1:0] posWords,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memRe,
  output logic                memWe,
  output logic [7:0]          memWdata,
  input  logic [7:0]          memRdata,
  output logic                busy,
  output logic                done,
  output logic [IDX_W-1:0]    fixCount,
  output logic                failed
);

  fixStrobe_t strobe;
  logic found, uncorr, atLimit, inRange;

  bchfix_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .decReady (decReady),
    .found    (found),
    .uncorr   (uncorr),
    .atLimit  (atLimit),
    .inRange  (inRange),
    .strobe   (strobe),
    .busy     (busy)
  );

  bchfix_dpath #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .POS_W        (POS_W),
    .MAX_ERR      (MAX_ERR)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .statWord (statWord),
    .posWords (posWords),
    .memRdata (memRdata),
    .found    (found),
    .uncorr   (uncorr),
    .atLimit  (atLimit),
    .inRange  (inRange),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .fixCount (fixCount),
    .failed   (failed)
  );

  assign memRe = strobe.rd;
  assign memWe = strobe.wr;
  assign done  = strobe.finish;

endmodule

// File: rtl/bchfix_apply_chk.sv
module bchfix_apply_chk #(
  parameter int MAX_ERR = 8,
  parameter int ADDR_W  = 9,
  parameter int IDX_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              decReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRe,
  input logic              memWe,
  input logic              busy,
  input logic              done,
  input logic [IDX_W-1:0]  fixCount,
  input logic              failed
);

  p_we_after_re_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($past(memRe) && memAddr == $past(memAddr)));

  p_access_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> busy);

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !decReady) |=> !busy);

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && decReady) |=> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_fail_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && failed) |-> (fixCount == '0));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(fixCount) <= MAX_ERR));

endmodule

bind bchfix_apply bchfix_apply_chk #(
  .MAX_ERR (MAX_ERR),
  .ADDR_W  (ADDR_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .decReady (decReady),
  .memAddr  (memAddr),
  .memRe    (memRe),
  .memWe    (memWe),
  .busy     (busy),
  .done     (done),
  .fixCount (fixCount),
  .failed   (failed)
);

// File: tb/bchfix_apply_tb.sv
`timescale 1ns/1ps
module bchfix_apply_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         decReady = 1'b0;
  logic [7:0]   statWord = '0;
  logic [127:0] posWords = '0;
  logic [8:0]   memAddr;
  logic         memRe, memWe;
  logic [7:0]   memWdata;
  logic [7:0]   memRdata = '0;
  logic         busy, done, failed;
  logic [3:0]   fixCount;

  logic [7:0] mem    [512];
  logic [7:0] golden [512];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bchfix_apply u_dut (
    .clk(clk), .rstN(rstN), .decReady(decReady), .statWord(statWord),
    .posWords(posWords), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .busy(busy), .done(done),
    .fixCount(fixCount), .failed(failed)
  );

  // behavioural sector buffer, one-cycle read latency
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] packPos(input int a, input int b, input int c,
      input int d, input int e, input int f, input int g, input int h);
    logic [127:0] w;
    int p [8];
    p[0] = a; p[1] = b; p[2] = c; p[3] = d;
    p[4] = e; p[5] = f; p[6] = g; p[7] = h;
    w = '0;
    for (int k = 0; k < 4; k++) begin
      w[k*32 +: 13]      = 13'(p[2*k]);
      w[k*32 + 13 +: 3]  = 3'b111;   // filler outside the fields
      w[k*32 + 16 +: 13] = 13'(p[2*k+1]);
      w[k*32 + 29 +: 3]  = 3'b101;
    end
    return w;
  endfunction

  task automatic inject(input int p);
    mem[p >> 3] = mem[p >> 3] ^ (8'd1 << (p & 7));
  endtask

  task automatic checkRestored(input string req);
    int diff = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== golden[i]) diff++;
    chk(diff == 0, req, "bytes differing from golden after job", diff, 0);
  endtask

  // reference model: expected writes, count, failure and latency
  task automatic runCase(input logic [7:0] st, input logic [127:0] pw,
                         input bit holdBusy, input string req);
    logic [7:0]  mdl [512];
    logic [16:0] expQ [$];
    logic [16:0] e;
    int n, lat, expCnt, p;
    bit expFail;
    for (int i = 0; i < 512; i++) mdl[i] = mem[i];
    n = int'(st[7:4]);
    if (n > 8) n = 8;
    expCnt  = 0;
    lat     = 1;
    expFail = st[1] && st[0];
    if (st[1] && !st[0]) begin
      for (int i = 0; i < n; i++) begin
        p = int'(pw[(i/2)*32 + (i%2)*16 +: 13]);
        if (p < 4096) begin
          mdl[p >> 3] = mdl[p >> 3] ^ (8'd1 << (p & 7));
          expQ.push_back({9'(p >> 3), mdl[p >> 3]});
          expCnt++;
          lat += 3;
        end else begin
          lat += 1;
        end
      end
    end
    @(negedge clk);
    statWord = st;
    posWords = pw;
    decReady = 1'b1;
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      if (holdBusy && k < lat) begin
        decReady = 1'b1;
        statWord = 8'h82;
        posWords = '0;
      end else begin
        decReady = 1'b0;
      end
      chk(busy === 1'b1, "R2", "busy during job", busy, 1);
      chk(done === (k == lat), "R8", "done timing", done, (k == lat));
      if (memWe === 1'b1) begin
        if (expQ.size() == 0) begin
          chk(0, req, "unexpected buffer write", memAddr, 0);
        end else begin
          e = expQ.pop_front();
          chk({memAddr, memWdata} === e, "R6", "write addr/data",
              {memAddr, memWdata}, e);
        end
      end
      if (k == lat) begin
        chk(fixCount === 4'(expCnt), req, "fixCount", fixCount, expCnt);
        chk(failed === expFail, req, "failed flag", failed, expFail);
      end
    end
    chk(expQ.size() == 0, req, "missing buffer writes", expQ.size(), 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R8", "idle after done",
        {busy, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      golden[i] = 8'((i * 37 + 11) & 255);
      mem[i]    = golden[i];
    end
    repeat (3) @(negedge clk);
    chk(!done && !busy && !memRe && !memWe, "R1", "outputs in reset",
        {done, busy, memRe, memWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !memRe && !memWe, "R1", "outputs after reset",
        {done, busy, memRe, memWe}, 0);

    // R2: inputs without the ready flag start nothing
    statWord = 8'h32;
    posWords = packPos(5, 6, 7, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!busy && !memRe && !memWe && !done, "R2", "idle without ready",
          {busy, memRe, memWe, done}, 0);
    end

    // R3: found flag clear, count and positions present
    runCase(8'h30, packPos(10, 20, 30, 0, 0, 0, 0, 0), 0, "R3");
    checkRestored("R3");

    // R4: uncorrectable
    runCase(8'h33, packPos(10, 20, 30, 0, 0, 0, 0, 0), 0, "R4");
    checkRestored("R4");

    // R6: single error
    inject(1234);
    runCase(8'h12, packPos(1234, 0, 0, 0, 0, 0, 0, 0), 0, "R6");
    checkRestored("R6");

    // R5/R6: eight errors, two in byte 0, ready held through the job (R2)
    inject(0); inject(7); inject(9); inject(4095);
    inject(2048); inject(100); inject(101); inject(3000);
    runCase(8'h82, packPos(0, 7, 9, 4095, 2048, 100, 101, 3000), 1, "R5");
    checkRestored("R5 R6 same-byte and held ready");

    // R5: count 3, later slots hold valid positions that must stay untouched
    inject(300); inject(301); inject(2222);
    runCase(8'h32, packPos(300, 301, 2222, 40, 41, 42, 43, 44), 0, "R5");
    checkRestored("R5 count limit");

    // R7: parity-area positions mixed in, boundary 4095/4096
    inject(500); inject(4095);
    runCase(8'h42, packPos(4096, 500, 8191, 4095, 0, 0, 0, 0), 0, "R7");
    checkRestored("R7");

    // R5: count 12 clamps to 8
    inject(1); inject(2); inject(3); inject(4);
    inject(1000); inject(1001); inject(1002); inject(1003);
    runCase(8'hC2, packPos(1, 2, 3, 4, 1000, 1001, 1002, 1003), 0, "R5");
    checkRestored("R5 count clamp");

    // R8: found with zero count
    runCase(8'h02, packPos(77, 0, 0, 0, 0, 0, 0, 0), 0, "R8");
    checkRestored("R8");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule